// File: doc/BRIEF.md
# Spread Spectrum Sweep Profile Generator

This block generates the slowly varying signed offset that a frequency synthesizer adds to its feedback divider. Adding the offset moves the output frequency back and forth between an upper and a lower excursion, which spreads its emitted energy over a band. Software supplies a positive excursion limit, a negative excursion limit written as a 4-bit two's-complement code, a dwell time per step counted in 280 ns units, and a shape select. The shape is either a triangle (pendulum) or a ramp that jumps back to the bottom (sawtooth).

The dwell unit is built from the system clock with a parameter giving the number of clock cycles in one 280 ns unit. A one-cycle step strobe marks every cycle in which the offset advances. The limits are taken in only at points where the sweep turns or wraps, so a sweep that is under way always completes its current leg. When the block is disabled, the offset stays at zero.

Top module: `ssc_profile_gen`

## Requirements
- R1: While reset is asserted, `ofs` is 0 and `step_stb` is 0. The limits in effect after reset are +0 (up) and magnitude 2 (down), so a block enabled from reset turns downward at its first step.
- R2: The down code is decoded as magnitude = (16 - code) mod 16. For example, 1111 gives 1, 1110 gives 2, 1000 gives 8 and 0000 gives 0. The lowest offset of the sweep is minus this magnitude.
- R3: While enabled, `step_stb` is high for exactly one cycle every max(dwell,1) x UNIT_CYCLES cycles. The first strobe comes that many cycles after enable rises or after reset is released with enable high.
- R4: While `ssc_en` is 0, `step_stb` stays 0 and `ofs` is 0 from the following clock edge on. The limit inputs are taken in every cycle while disabled, and the next run starts at offset 0 moving upward.
- R5: `ofs` changes only at the clock edge that ends a cycle with `step_stb` high, or when the block is disabled.
- R6: With `pend_mode`=1, each step adds 1 until the offset reaches +up. At the step after that, the direction reverses and 1 is subtracted until -down is reached, where the direction reverses again. The result is a triangle.
- R7: With `pend_mode`=0, each step adds 1 while the offset is below +up. The step taken at +up or above loads -down, giving a sawtooth.
- R8: New values on `up_lim` and `dn_code` during an enabled sweep have no effect until the next reversal (pendulum) or wrap (sawtooth). At that step the new values are adopted.
- R9: At a reversal, the next offset is the one-step move in the new direction, clamped into [-new down, +new up]. This holds even if the old offset lay outside the new range.
- R10: With up = 0 and down magnitude 0, the offset remains 0 at every step in both shapes, while strobes continue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| ssc_en | input | 1 | Sweep enable; 0 forces zero offset |
| up_lim | input | 4 | Upper excursion, unsigned |
| dn_code | input | 4 | Lower excursion as a two's-complement code |
| dwell | input | 6 | Step dwell in 280 ns units (0 treated as 1) |
| pend_mode | input | 1 | 1 = triangle sweep, 0 = sawtooth sweep |
| ofs | output | 5 | Signed offset for the feedback divider |
| step_stb | output | 1 | One-cycle pulse marking a step |

## Verification
The step strobe is combinational from the timer state, so it is valid in the same cycle the dwell count runs out. The offset that the step produces appears after the next rising edge. The bench therefore takes the strobe at one falling edge and compares the offset at the next falling edge against a queue filled by a requirement-level model. Strobe spacing is measured in falling edges counted from enable, so the first strobe is expected max(dwell,1) x UNIT_CYCLES cycles after enable. A disable clears the offset one edge later, and the zero checks begin on the falling edge after that. Limit changes are applied only while the dwell is long, so an input change never lands in the same cycle as a step.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int LIM_W   = 4;
  localparam int DWELL_W = 6;
  localparam int OFS_W   = LIM_W + 1;

  typedef logic [LIM_W-1:0]         lim_t;
  typedef logic signed [OFS_W-1:0]  ofs_t;
  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dir_e;

  // two's-complement code of a negative bound -> its magnitude
  function automatic lim_t dn_magnitude(lim_t code);
    return lim_t'(~code + lim_t'(1));
  endfunction
endpackage

// File: rtl/ssc_dwell_timer.sv
module ssc_dwell_timer #(
  parameter int unsigned UNIT_CYCLES = 28,
  parameter int unsigned DWELL_W     = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic [DWELL_W-1:0] dwell_i,
  output logic               step_o
);
  localparam int unsigned PW = (UNIT_CYCLES > 2) ? $clog2(UNIT_CYCLES) : 1;
  localparam logic [PW-1:0] PRESC_LAST = PW'(UNIT_CYCLES - 1);

  logic [PW-1:0]      presc_q, presc_d;
  logic [DWELL_W-1:0] units_q, units_d, dwell_eff;
  logic               unit_tick, tmr_ce;

  assign dwell_eff = (dwell_i == '0) ? DWELL_W'(1) : dwell_i;
  assign unit_tick = (presc_q == PRESC_LAST);
  assign step_o    = en_i & unit_tick & (units_q >= (dwell_eff - DWELL_W'(1)));
  assign tmr_ce    = en_i | (presc_q != '0) | (units_q != '0);

  always_comb begin
    presc_d = presc_q;
    units_d = units_q;
    if (!en_i) begin
      presc_d = '0;
      units_d = '0;
    end else if (unit_tick) begin
      presc_d = '0;
      units_d = step_o ? '0 : units_q + DWELL_W'(1);
    end else begin
      presc_d = presc_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      units_q <= '0;
    end else if (tmr_ce) begin
      presc_q <= presc_d;
      units_q <= units_d;
    end
  end
endmodule

// File: rtl/ssc_limit_hold.sv
module ssc_limit_hold
  import ssc_pkg::*;
#(
  parameter lim_t RST_UP      = lim_t'(0),
  parameter lim_t RST_DN_CODE = lim_t'(4'b1110)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  lim_t up_i,
  input  lim_t dn_code_i,
  output lim_t up_act_o,
  output lim_t dn_act_o,
  output lim_t up_new_o,
  output lim_t dn_new_o
);
  lim_t up_q, dn_q;

  assign up_new_o = up_i;
  assign dn_new_o = dn_magnitude(dn_code_i);
  assign up_act_o = up_q;
  assign dn_act_o = dn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= RST_UP;
      dn_q <= dn_magnitude(RST_DN_CODE);
    end else if (load_i) begin
      up_q <= up_new_o;
      dn_q <= dn_new_o;
    end
  end
endmodule

// File: rtl/ssc_sweep_core.sv
module ssc_sweep_core
  import ssc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic step_i,
  input  logic pend_i,
  input  lim_t up_act_i,
  input  lim_t dn_act_i,
  input  lim_t up_new_i,
  input  lim_t dn_new_i,
  output ofs_t ofs_o,
  output logic load_o
);
  localparam int EXT_W = OFS_W + 1;
  typedef logic signed [EXT_W-1:0] ext_t;

  ofs_t ofs_q, ofs_d;
  dir_e dir_q, dir_d;
  ext_t ofs_x, top_act, bot_act, top_new, bot_new, turn_val, clamp_val;
  logic hit_top, hit_bot, at_bound, core_ce;

  assign ofs_x   = ext_t'(ofs_q);
  assign top_act = $signed({2'b00, up_act_i});
  assign bot_act = -$signed({2'b00, dn_act_i});
  assign top_new = $signed({2'b00, up_new_i});
  assign bot_new = -$signed({2'b00, dn_new_i});

  assign hit_top  = (ofs_x >= top_act);
  assign hit_bot  = (ofs_x <= bot_act);
  assign at_bound = (pend_i && dir_q == DIR_DOWN) ? hit_bot : hit_top;
  assign load_o   = !en_i | (step_i & at_bound);
  assign core_ce  = !en_i | step_i;
  assign ofs_o    = ofs_q;

  // one move in the reversed direction, kept inside the newly adopted range
  always_comb begin
    turn_val = (dir_q == DIR_UP) ? ofs_x - ext_t'(1) : ofs_x + ext_t'(1);
    if (turn_val > top_new)      clamp_val = top_new;
    else if (turn_val < bot_new) clamp_val = bot_new;
    else                         clamp_val = turn_val;
  end

  always_comb begin
    ofs_d = ofs_q;
    dir_d = dir_q;
    if (!en_i) begin
      ofs_d = '0;
      dir_d = DIR_UP;
    end else if (step_i) begin
      if (!pend_i) begin
        dir_d = DIR_UP;
        ofs_d = hit_top ? ofs_t'(bot_new) : ofs_t'(ofs_x + ext_t'(1));
      end else if (dir_q == DIR_UP) begin
        if (hit_top) begin
          dir_d = DIR_DOWN;
          ofs_d = ofs_t'(clamp_val);
        end else begin
          ofs_d = ofs_t'(ofs_x + ext_t'(1));
        end
      end else begin
        if (hit_bot) begin
          dir_d = DIR_UP;
          ofs_d = ofs_t'(clamp_val);
        end else begin
          ofs_d = ofs_t'(ofs_x - ext_t'(1));
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= '0;
      dir_q <= DIR_UP;
    end else if (core_ce) begin
      ofs_q <= ofs_d;
      dir_q <= dir_d;
    end
  end
endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen #(
  parameter int unsigned   UNIT_CYCLES = 28,
  parameter ssc_pkg::lim_t RST_UP      = ssc_pkg::lim_t'(0),
  parameter ssc_pkg::lim_t RST_DN_CODE = ssc_pkg::lim_t'(4'b1110)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                ssc_en,
  input  logic [ssc_pkg::LIM_W-1:0]           up_lim,
  input  logic [ssc_pkg::LIM_W-1:0]           dn_code,
  input  logic [ssc_pkg::DWELL_W-1:0]         dwell,
  input  logic                                pend_mode,
  output logic signed [ssc_pkg::OFS_W-1:0]    ofs,
  output logic                                step_stb
);
  import ssc_pkg::*;

  lim_t up_act, dn_act, up_new, dn_new;
  logic lim_load;

  ssc_dwell_timer #(
    .UNIT_CYCLES (UNIT_CYCLES),
    .DWELL_W     (DWELL_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (ssc_en),
    .dwell_i (dwell),
    .step_o  (step_stb)
  );

  ssc_limit_hold #(
    .RST_UP      (RST_UP),
    .RST_DN_CODE (RST_DN_CODE)
  ) u_limits (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (lim_load),
    .up_i      (up_lim),
    .dn_code_i (dn_code),
    .up_act_o  (up_act),
    .dn_act_o  (dn_act),
    .up_new_o  (up_new),
    .dn_new_o  (dn_new)
  );

  ssc_sweep_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (ssc_en),
    .step_i   (step_stb),
    .pend_i   (pend_mode),
    .up_act_i (up_act),
    .dn_act_i (dn_act),
    .up_new_i (up_new),
    .dn_new_i (dn_new),
    .ofs_o    (ofs),
    .load_o   (lim_load)
  );
endmodule

// File: rtl/ssc_profile_gen_chk.sv
module ssc_profile_gen_chk (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             ssc_en,
  input logic                             pend_mode,
  input logic                             step_stb,
  input logic signed [ssc_pkg::OFS_W-1:0] ofs
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (ofs == '0 && !step_stb)
        else $error("offset or strobe active during reset");
    end
  end

  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ssc_en |=> (ofs == '0));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ssc_en |-> !step_stb);

  assert_hold_between_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ssc_en && !step_stb) |=> $stable(ofs));

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_stb |=> !step_stb);

  assert_ramp_or_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ssc_en && step_stb && !pend_mode) |=> ((ofs - $past(ofs) == 1) || (ofs <= 0)));
endmodule

bind ssc_profile_gen ssc_profile_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ssc_en    (ssc_en),
  .pend_mode (pend_mode),
  .step_stb  (step_stb),
  .ofs       (ofs)
);

// File: tb/ssc_profile_gen_bench.sv
module ssc_profile_gen_bench;
  import ssc_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int UNIT       = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ssc_en, pend_mode, step_stb;
  lim_t up_lim, dn_code;
  logic [DWELL_W-1:0] dwell;
  ofs_t ofs;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssc_profile_gen #(.UNIT_CYCLES(UNIT)) u_ssc_profile_gen (
    .clk(clk), .rst_n(rst_n), .ssc_en(ssc_en), .up_lim(up_lim),
    .dn_code(dn_code), .dwell(dwell), .pend_mode(pend_mode),
    .ofs(ofs), .step_stb(step_stb)
  );

  int total = 0;
  int bad = 0;
  int exp_q[$];
  string tag_q[$];
  int exp_period = UNIT;
  int run_cnt = 0;
  bit cmp_pend = 1'b0;
  int m_ofs, m_up, m_dn;
  bit m_dir;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int mag(int code);
    return (16 - code) % 16;
  endfunction

  // requirement-level model of one step, using the present inputs as new limits
  task automatic model_step();
    int nu, nd, v;
    nu = int'(up_lim);
    nd = mag(int'(dn_code));
    if (!pend_mode) begin
      m_dir = 1'b1;
      if (m_ofs >= m_up) begin m_up = nu; m_dn = nd; m_ofs = -nd; end
      else m_ofs++;
    end else if (m_dir) begin
      if (m_ofs >= m_up) begin
        m_up = nu; m_dn = nd; m_dir = 1'b0; v = m_ofs - 1;
        if (v > m_up) v = m_up;
        if (v < -m_dn) v = -m_dn;
        m_ofs = v;
      end else m_ofs++;
    end else begin
      if (m_ofs <= -m_dn) begin
        m_up = nu; m_dn = nd; m_dir = 1'b1; v = m_ofs + 1;
        if (v > m_up) v = m_up;
        if (v < -m_dn) v = -m_dn;
        m_ofs = v;
      end else m_ofs--;
    end
  endtask

  task automatic push_steps(int n, string req);
    for (int i = 0; i < n; i++) begin
      model_step();
      exp_q.push_back(m_ofs);
      tag_q.push_back(req);
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || cmp_pend) @(negedge clk);
  endtask

  task automatic start(int up, int dn, int dw, bit pd);
    @(posedge clk); #1;
    ssc_en = 1'b0;
    up_lim = lim_t'(up); dn_code = lim_t'(dn);
    dwell = DWELL_W'(dw); pend_mode = pd;
    repeat (2) @(posedge clk);
    #1;
    ssc_en = 1'b1;
    m_ofs = 0; m_dir = 1'b1; m_up = up; m_dn = mag(dn);
    exp_period = ((dw == 0) ? 1 : dw) * UNIT;
  endtask

  // scoreboard monitor: strobe seen at one falling edge, offset compared at the next
  always @(negedge clk) begin : mon
    int e;
    string t;
    if (cmp_pend && exp_q.size() != 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(int'(ofs) == e, t, "offset after step", int'(ofs), e);
    end
    cmp_pend = rst_n && step_stb;
    if (rst_n && ssc_en) begin
      run_cnt++;
      if (step_stb) begin
        chk(run_cnt == exp_period, "R3", "step spacing", run_cnt, exp_period);
        run_cnt = 0;
      end
    end else begin
      run_cnt = 0;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    ssc_en = 1'b1; up_lim = 4'd3; dn_code = 4'b1111; dwell = 6'd1; pend_mode = 1'b1;
    m_ofs = 0; m_dir = 1'b1; m_up = 0; m_dn = 2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ofs == '0, "R1", "offset in reset", int'(ofs), 0);
    chk(step_stb == 1'b0, "R1", "strobe in reset", int'(step_stb), 0);
    // R1: reset limits (+0, -2) make the first step turn downward
    push_steps(3, "R1");
    @(posedge clk); #1;
    rst_n = 1'b1;
    drain();

    start(3, 4'b1110, 1, 1'b1); push_steps(11, "R6"); drain();
    start(2, 4'b1110, 5, 1'b1); push_steps(4, "R3"); drain();

    // R4: disabled means zero offset and no strobes
    @(posedge clk); #1;
    ssc_en = 1'b0; up_lim = 4'd7; dn_code = 4'b1001;
    @(posedge clk); #1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(ofs == '0, "R4", "offset while disabled", int'(ofs), 0);
      chk(step_stb == 1'b0, "R4", "strobe while disabled", int'(step_stb), 0);
    end
    // R4: limits taken while disabled drive the next run
    @(posedge clk); #1;
    ssc_en = 1'b1; pend_mode = 1'b0; dwell = 6'd1;
    m_ofs = 0; m_dir = 1'b1; m_up = 7; m_dn = 7; exp_period = UNIT;
    push_steps(9, "R4"); drain();

    start(1, 4'b1000, 1, 1'b0); push_steps(10, "R2"); drain();
    start(2, 4'b1101, 1, 1'b0); push_steps(9, "R7"); drain();

    // R8: new limits mid-ramp wait for the wrap
    start(3, 4'b1110, 4, 1'b0); push_steps(2, "R8"); drain();
    up_lim = 4'd0; dn_code = 4'b1111;
    push_steps(4, "R8"); drain();

    // R9: reversal clamps into the new, narrower top
    start(4, 4'b1111, 4, 1'b1); push_steps(2, "R9"); drain();
    up_lim = 4'd1; dn_code = 4'b1000;
    push_steps(13, "R9"); drain();

    start(0, 4'b0000, 0, 1'b1); push_steps(3, "R10"); drain();
    start(0, 4'b0000, 0, 1'b0); push_steps(3, "R10"); drain();
    start(1, 4'b1111, 63, 1'b1); push_steps(2, "R3"); drain();

    @(posedge clk); #1;
    ssc_en = 1'b0;
    repeat (3) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule